// File: doc/BRIEF.md
# Ring-Cascaded FIFO Segment

This block is one segment of a first-in first-out buffer built so that several identical segments can be joined into a deeper queue. Each segment holds a small local memory. It also holds a write-ownership bit and a read-ownership bit, and those bits travel around a ring of segments. Only the segment that owns the write token may store a word. Only the segment that owns the read token may deliver one. When a segment stores into, or delivers from, its highest address, it gives up that token. It then raises a one-cycle pass pulse towards the next segment in the ring, which takes the token on the following edge. A strap input picks the segment that owns both tokens after reset. Because the data follows the tokens, the joined segments behave like one FIFO whose depth is the sum of theirs, and word order is kept across every hand-over and every lap of the ring.

A second strap selects cascade or stand-alone operation. When it is low, the segment owns both tokens permanently and ignores its pass inputs. Its shared pass-out pin then reports a half-full flag, and a rewind input restarts reading from address zero so that stored data can be sent again. In cascade operation the rewind input has no effect. A segment drives its data output only in the cycle after it has itself performed a read, so the data buses of all segments can simply be ORed together. The empty and full indications are active-low so that they can be combined the same way.

Top module: `chain_fifo_node`

## Requirements
- R1: In the cycle after synchronous reset, a segment with `lead_sel`=1 in cascade mode shows `wr_grant`=1 and a segment with `lead_sel`=0 shows `wr_grant`=0. Every segment shows `empty_n`=0, `full_n`=1, `rd_grant`=0, `rd_valid`=0 and `rd_q`=0.
- R2: A word is stored only on an edge where `wr_en`=1 and `wr_grant`=1. `wr_grant` is 1 only while the segment owns the write token, is not full and is not rewinding. A write attempted without a grant changes no state.
- R3: A word is removed only on an edge where `rd_en`=1 and `rd_grant`=1. The word appears on `rd_q` with `rd_valid`=1 in the cycle after that edge. `rd_q` is all zeros whenever `rd_valid`=0.
- R4: In cascade mode, a store into the highest address (DEPTH-1) releases the write token on that same edge. `wpass_hf_out` is then 1 for exactly the next cycle.
- R5: In cascade mode, a read from the highest address releases the read token on that same edge. `rpass_out` is then 1 for exactly the next cycle.
- R6: A segment that samples `wpass_in`=1 (or `rpass_in`=1) on an edge owns that token from that edge onward, so its grant can first be 1 in the cycle that follows.
- R7: A ring of segments (each pass output wired to the next segment's pass input, the last wired back to the first) returns words in the order they were written, across several laps of the ring.
- R8: `full_n`=0 exactly when DEPTH words are held and `empty_n`=0 exactly when none are held. The two are never low together.
- R9: With `cascade_en`=0 the segment owns both tokens whatever `lead_sel`, `wpass_in` and `rpass_in` are. `rpass_out` stays 0, and `wpass_hf_out` is 1 when more than DEPTH/2 words are held (registered, updated on the edge that changes occupancy).
- R10: With `cascade_en`=0, an edge with `rt`=1 moves the read address to 0 and sets occupancy to the number of words written since reset (capped at DEPTH), and it accepts no read or write. With `cascade_en`=1, `rt` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Synchronous active-high reset |
| cascade_en | input | 1 | Strap: 1 = ring member, 0 = stand-alone |
| lead_sel | input | 1 | Strap: this segment owns both tokens after reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_grant | output | 1 | Segment will store a word if `wr_en` is high |
| rd_en | input | 1 | Read request |
| rd_grant | output | 1 | Segment will deliver a word if `rd_en` is high |
| rd_q | output | DATA_W | Delivered word, zero when not valid |
| rd_valid | output | 1 | `rd_q` carries a word from this segment |
| rt | input | 1 | Rewind reads to address 0 (stand-alone only) |
| wpass_in | input | 1 | Write token arriving from the previous segment |
| wpass_hf_out | output | 1 | Write token pass pulse (cascade) or half-full flag (stand-alone) |
| rpass_in | input | 1 | Read token arriving from the previous segment |
| rpass_out | output | 1 | Read token pass pulse |
| empty_n | output | 1 | Low when no words are held |
| full_n | output | 1 | Low when DEPTH words are held |

## Verification
If a token bit is wrong, either two segments grant at once or none does. Either way the merged read stream differs from the write order at the first word that crosses the faulty hand-over. The scoreboard catches this within one ring lap. A pass pulse that is lost, doubled or late shows within one or two cycles as a grant missing from, or surplus at, the neighbour, which the hand-over checks sample directly. A bad occupancy count shows as a flag, or a stand-alone half-full level, that is wrong on the edge that crosses the boundary. Rewind faults show as a replayed word of the wrong value or as a wrong count of replayed words.

// File: rtl/chain_fifo_pkg.sv
package chain_fifo_pkg;

  // Advance a circular address, wrapping after the top location.
  function automatic int unsigned wrap_next(input int unsigned p, input int unsigned top);
    return (p == top) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/chain_tok_ctl.sv
module chain_tok_ctl (
  input  logic clk,
  input  logic rst,
  input  logic cascade_en,
  input  logic lead_sel,
  input  logic pass_in,
  input  logic fire_last,
  output logic own,
  output logic pass_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      own      <= lead_sel;
      pass_out <= 1'b0;
    end else begin
      pass_out <= cascade_en & fire_last;
      if (!cascade_en)    own <= lead_sel;
      else if (fire_last) own <= 1'b0;
      else if (pass_in)   own <= 1'b1;
    end
  end

  // R4/R5: a pass pulse never lasts two cycles
  assert_pass_single_R4: assert property (@(posedge clk) disable iff (rst)
    pass_out |=> !pass_out);
  // R4/R5: the token is gone after the last location is used
  assert_release_R5: assert property (@(posedge clk) disable iff (rst)
    (cascade_en && fire_last) |=> !own);
  // R6: an arriving pass is taken on that edge
  assert_take_R6: assert property (@(posedge clk) disable iff (rst)
    (cascade_en && pass_in && !fire_last) |=> own);

endmodule

// File: rtl/chain_store.sv
module chain_store #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/chain_fifo_node.sv
module chain_fifo_node
  import chain_fifo_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cascade_en,
  input  logic              lead_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_grant,
  input  logic              rd_en,
  output logic              rd_grant,
  output logic [DATA_W-1:0] rd_q,
  output logic              rd_valid,
  input  logic              rt,
  input  logic              wpass_in,
  output logic              wpass_hf_out,
  input  logic              rpass_in,
  output logic              rpass_out,
  output logic              empty_n,
  output logic              full_n
);

  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int HALF = DEPTH / 2;
  localparam logic [AW-1:0] TOP_A = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count, count_nx, filled;
  logic          wown, rown, w_hold, r_hold;
  logic          solo_rt, wr_fire, rd_fire, w_last, r_last;
  logic          wpass, hf_q, rv_q;
  logic [DATA_W-1:0] word;

  assign solo_rt  = rt & ~cascade_en;
  assign w_hold   = wown | ~cascade_en;
  assign r_hold   = rown | ~cascade_en;
  assign wr_grant = w_hold & (count != FULL_C) & ~solo_rt;
  assign rd_grant = r_hold & (count != '0) & ~solo_rt;
  assign wr_fire  = wr_en & wr_grant;
  assign rd_fire  = rd_en & rd_grant;
  assign w_last   = wr_fire & (wptr == TOP_A);
  assign r_last   = rd_fire & (rptr == TOP_A);

  chain_tok_ctl u_wtok (
    .clk(clk), .rst(rst), .cascade_en(cascade_en), .lead_sel(lead_sel),
    .pass_in(wpass_in), .fire_last(w_last), .own(wown), .pass_out(wpass)
  );

  chain_tok_ctl u_rtok (
    .clk(clk), .rst(rst), .cascade_en(cascade_en), .lead_sel(lead_sel),
    .pass_in(rpass_in), .fire_last(r_last), .own(rown), .pass_out(rpass_out)
  );

  chain_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(wr_fire), .waddr(wptr), .wdata(wr_data),
    .re(rd_fire), .raddr(rptr), .rdata(word)
  );

  always_ff @(posedge clk) begin
    if (rst) wptr <= '0;
    else if (wr_fire) wptr <= AW'(wrap_next(32'(wptr), DEPTH - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) rptr <= '0;
    else if (solo_rt) rptr <= '0;
    else if (rd_fire) rptr <= AW'(wrap_next(32'(rptr), DEPTH - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) filled <= '0;
    else if (wr_fire && filled != FULL_C) filled <= filled + CW'(1);
  end

  always_comb begin
    count_nx = count;
    if (solo_rt) count_nx = filled;
    else begin
      case ({wr_fire, rd_fire})
        2'b10:   count_nx = count + CW'(1);
        2'b01:   count_nx = count - CW'(1);
        default: count_nx = count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      hf_q  <= 1'b0;
      rv_q  <= 1'b0;
    end else begin
      count <= count_nx;
      hf_q  <= (count_nx > CW'(HALF));
      rv_q  <= rd_fire;
    end
  end

  assign rd_valid     = rv_q;
  assign rd_q         = rv_q ? word : '0;
  assign wpass_hf_out = cascade_en ? wpass : hf_q;
  assign empty_n      = (count != '0);
  assign full_n       = (count != FULL_C);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_C);
  assert_flags_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(!empty_n && !full_n));
  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && !rd_fire) |=> (count == $past(count) + CW'(1)));
  assert_valid_src_R3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_grant && rd_en));
  assert_solo_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (!cascade_en && !$past(cascade_en)) |-> !rpass_out);

endmodule

// File: tb/sim_chain_fifo_node.sv
module sim_chain_fifo_node;

  localparam int DW = 16;
  localparam int DP = 4;

  logic clk = 0;
  logic rst = 1;
  always #5 clk = ~clk;

  logic          wr_en = 0, rd_en = 0, rt = 0;
  logic [DW-1:0] wr_data = '0;
  logic [2:0]    wg, rg, rv, en_n, fu_n, wpo, rpo;
  logic [DW-1:0] rq [3];

  chain_fifo_node #(.DATA_W(DW), .DEPTH(DP)) u0 (
    .clk(clk), .rst(rst), .cascade_en(1'b1), .lead_sel(1'b1),
    .wr_en(wr_en), .wr_data(wr_data), .wr_grant(wg[0]),
    .rd_en(rd_en), .rd_grant(rg[0]), .rd_q(rq[0]), .rd_valid(rv[0]), .rt(rt),
    .wpass_in(wpo[2]), .wpass_hf_out(wpo[0]), .rpass_in(rpo[2]), .rpass_out(rpo[0]),
    .empty_n(en_n[0]), .full_n(fu_n[0]));
  chain_fifo_node #(.DATA_W(DW), .DEPTH(DP)) u1 (
    .clk(clk), .rst(rst), .cascade_en(1'b1), .lead_sel(1'b0),
    .wr_en(wr_en), .wr_data(wr_data), .wr_grant(wg[1]),
    .rd_en(rd_en), .rd_grant(rg[1]), .rd_q(rq[1]), .rd_valid(rv[1]), .rt(rt),
    .wpass_in(wpo[0]), .wpass_hf_out(wpo[1]), .rpass_in(rpo[0]), .rpass_out(rpo[1]),
    .empty_n(en_n[1]), .full_n(fu_n[1]));
  chain_fifo_node #(.DATA_W(DW), .DEPTH(DP)) u2 (
    .clk(clk), .rst(rst), .cascade_en(1'b1), .lead_sel(1'b0),
    .wr_en(wr_en), .wr_data(wr_data), .wr_grant(wg[2]),
    .rd_en(rd_en), .rd_grant(rg[2]), .rd_q(rq[2]), .rd_valid(rv[2]), .rt(rt),
    .wpass_in(wpo[1]), .wpass_hf_out(wpo[2]), .rpass_in(rpo[1]), .rpass_out(rpo[2]),
    .empty_n(en_n[2]), .full_n(fu_n[2]));

  // stand-alone segment, pass inputs held high to show they are ignored
  logic          w3 = 0, r3 = 0, rt3 = 0;
  logic [DW-1:0] d3 = '0, q3;
  logic          wg3, rg3, rv3, hf3, rp3, en3, fu3;
  chain_fifo_node #(.DATA_W(DW), .DEPTH(DP)) u3 (
    .clk(clk), .rst(rst), .cascade_en(1'b0), .lead_sel(1'b0),
    .wr_en(w3), .wr_data(d3), .wr_grant(wg3),
    .rd_en(r3), .rd_grant(rg3), .rd_q(q3), .rd_valid(rv3), .rt(rt3),
    .wpass_in(1'b1), .wpass_hf_out(hf3), .rpass_in(1'b1), .rpass_out(rp3),
    .empty_n(en3), .full_n(fu3));

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] sb [$];
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // scoreboard monitor for the ring (R3, R7)
  always @(negedge clk) begin
    if (!rst && (|rv)) begin
      chk("R3 one source", 32'($countones(rv)), 32'd1);
      if (sb.size() == 0) chk("R7 unexpected word", 32'(rq[0] | rq[1] | rq[2]), 32'hFFFF_FFFF);
      else chk("R7 order", 32'(rq[0] | rq[1] | rq[2]), 32'(sb.pop_front()));
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
      finish_up();
    end
  end

  task automatic write_word(input logic [DW-1:0] d);
    @(negedge clk);
    while (!(|wg)) @(negedge clk);
    wr_en = 1; wr_data = d; sb.push_back(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic read_word();
    @(negedge clk);
    while (!(|rg)) @(negedge clk);
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic solo_write(input logic [DW-1:0] d);
    @(negedge clk); w3 = 1; d3 = d;
    @(negedge clk); w3 = 0;
  endtask

  task automatic solo_read(input logic [DW-1:0] exp, input string req);
    @(negedge clk); r3 = 1;
    @(negedge clk); r3 = 0;
    chk(req, 32'({rv3, q3}), 32'({1'b1, exp}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 write grants", 32'(wg), 32'b001);
    chk("R1 read grants", 32'(rg), 32'b000);
    chk("R1 empty_n", 32'(en_n), 32'b000);
    chk("R1 full_n", 32'(fu_n), 32'b111);
    chk("R1 data idle", 32'({rv, rq[0] | rq[1] | rq[2]}), 32'd0);
    chk("R9 solo owns write", 32'(wg3), 32'd1);

    // R3 read on empty is refused
    rd_en = 1; @(negedge clk); rd_en = 0;
    @(negedge clk);
    chk("R3 empty read refused", 32'(rv), 32'd0);

    // fill u0 and watch the hand-over (R4, R6)
    for (int i = 0; i < 4; i++) write_word(16'h0A00 + 16'(i));
    chk("R4 pass pulse", 32'(wpo[0]), 32'd1);
    chk("R4 token released", 32'(wg[0]), 32'd0);
    chk("R6 not yet taken", 32'(wg[1]), 32'd0);
    chk("R8 u0 full", 32'(fu_n[0]), 32'd0);
    wr_en = 1; wr_data = 16'hDEAD;  // nobody owns the token: refused
    @(negedge clk); wr_en = 0;
    chk("R4 pulse one cycle", 32'(wpo[0]), 32'd0);
    chk("R6 token taken", 32'(wg[1]), 32'd1);
    chk("R2 refused write", 32'(en_n[1]), 32'd0);

    for (int i = 0; i < 2; i++) write_word(16'h0B00 + 16'(i));
    for (int i = 0; i < 4; i++) read_word();
    chk("R5 read pass pulse", 32'(rpo[0]), 32'd1);
    chk("R5 read token released", 32'(rg[0]), 32'd0);
    @(negedge clk);
    chk("R5 pulse one cycle", 32'(rpo[0]), 32'd0);
    chk("R6 read token taken", 32'(rg[1]), 32'd1);

    // fill the whole ring (R8, R2)
    for (int i = 0; i < 10; i++) write_word(16'h0C00 + 16'(i));
    repeat (2) @(negedge clk);
    chk("R8 all full", 32'(fu_n), 32'd0);
    chk("R2 no grant when full", 32'(wg), 32'd0);
    for (int i = 0; i < 12; i++) read_word();
    repeat (2) @(negedge clk);
    chk("R7 drained", 32'(sb.size()), 32'd0);
    chk("R8 all empty", 32'(en_n), 32'd0);

    // concurrent stream over several laps (R7)
    fork
      for (int i = 0; i < 30; i++) write_word(16'h1000 + 16'(i));
      begin
        repeat (5) @(negedge clk);
        for (int i = 0; i < 30; i++) read_word();
      end
    join
    repeat (3) @(negedge clk);
    chk("R7 stream complete", 32'(sb.size()), 32'd0);

    // rewind is ignored in cascade mode (R10)
    for (int i = 0; i < 2; i++) write_word(16'h2000 + 16'(i));
    @(negedge clk); rt = 1; @(negedge clk); rt = 0;
    for (int i = 0; i < 2; i++) read_word();
    repeat (2) @(negedge clk);
    chk("R10 no replay in cascade", 32'({rg, en_n}), 32'd0);
    chk("R10 queue empty", 32'(sb.size()), 32'd0);

    // stand-alone segment (R9, R10)
    solo_write(16'h3000);
    solo_write(16'h3001);
    chk("R9 half-full at DEPTH/2", 32'(hf3), 32'd0);
    solo_write(16'h3002);
    chk("R9 half-full above DEPTH/2", 32'(hf3), 32'd1);
    chk("R9 no read pass", 32'(rp3), 32'd0);
    solo_read(16'h3000, "R9 solo read 0");
    solo_read(16'h3001, "R9 solo read 1");
    @(negedge clk); rt3 = 1; r3 = 1;
    @(negedge clk); rt3 = 0; r3 = 0;
    chk("R10 no read during rewind", 32'(rv3), 32'd0);
    solo_read(16'h3000, "R10 replay 0");
    solo_read(16'h3001, "R10 replay 1");
    solo_read(16'h3002, "R10 replay 2");
    chk("R10 empty after replay", 32'({rg3, en3}), 32'd0);

    finish_up();
  end

endmodule